// File: doc/BRIEF.md
# Sprite Table DMA Engine

This block copies one page of bytes from the system bus into the sprite attribute memory of a video unit. Software starts a copy by writing a page number to a trigger register. From the next cycle the engine halts the processor, masters the bus, and moves the page one byte at a time. Each byte is fetched with an ordinary bus read and then pushed to the sprite data port on the following cycle.

The copy is cycle-exact. One idle lead-in cycle comes first. A second idle cycle is added when the trigger lands on an odd CPU cycle, so that every read falls on an even cycle and every write on an odd one. Strictly alternating read and write cycles follow. The sprite memory stores four-byte entries: vertical position, tile number, attribute byte, horizontal position. The engine keeps that layout by delivering the bytes in ascending source order. The sprite memory's own write pointer advances once per write and wraps at 256.

Top module: `sprite_dma`

## Requirements
- R1: A trigger write of value N while idle makes the engine read source addresses N*256+0 up to N*256+255, in ascending order. `bus_addr` is {N, byte index}, and a source page may sit anywhere in the 16-bit space, including page 0xFF.
- R2: Each transfer performs exactly 256 bus reads and 256 sprite writes. Each write carries the byte returned by the bus read of the cycle before.
- R3: `halt` rises on the cycle after the accepted trigger and stays high for 513 cycles when the trigger cycle has `cyc_odd`=0, or for 514 cycles when it has `cyc_odd`=1.
- R4: Reads happen only on cycles with `cyc_odd`=0 and writes only on cycles with `cyc_odd`=1. A read and a write never share a cycle, and every read is followed directly by its write.
- R5: The first halted cycle is idle. With an odd trigger cycle the second halted cycle is idle as well, so the first read comes in halted cycle 1 (even trigger) or 2 (odd trigger), counting from 0.
- R6: `done` is high for exactly one cycle: the cycle right after the 256th write, which is also the first cycle with `halt` low.
- R7: A trigger write arriving while `halt` is high has no effect: the source page, the byte order and the transfer length stay as they were.
- R8: While the synchronous reset `rst` is high, `halt`, `done`, `bus_rd` and `spr_wr` are low. The next transfer after reset starts again at byte index 0.
- R9: Byte i of the page lands at sprite address (P+i) mod 256, where P is the sprite write pointer before the transfer. The four-byte entry layout is therefore kept, and the pointer wraps past 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_wr | input | 1 | Write strobe of the trigger register |
| trig_data | input | 8 | Page number written with the strobe |
| cyc_odd | input | 1 | High during odd CPU cycles |
| bus_rd | output | 1 | Bus read request this cycle |
| bus_addr | output | 16 | Bus read address |
| bus_rdata | input | 8 | Byte returned by the bus in the same cycle |
| spr_wr | output | 1 | Sprite data port write strobe |
| spr_wdata | output | 8 | Byte written to the sprite data port |
| halt | output | 1 | Holds the processor while high |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit data and a 256-byte transfer. These are the only values for which the 513/514-cycle budget and the 64-entry sprite layout hold. With them the bench can reach the highest page (0xFF), sprite pointer wrap from 0xFD onward, triggers on both cycle parities, spurious triggers early and late in a copy, and a reset in the middle of a copy.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [1:0] {
    SD_IDLE  = 2'd0,
    SD_LEAD  = 2'd1,
    SD_FETCH = 2'd2,
    SD_STORE = 2'd3
  } sdma_state_e;

  // Halted cycles of one copy: lead-in, optional alignment, read/write pairs.
  function automatic int unsigned sdma_xfer_cycles(input int unsigned nbytes,
                                                    input logic odd_start);
    return 2 * nbytes + 1 + (odd_start ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic cyc_odd,
  input  logic last_idx,
  output logic rd_fire,
  output logic wr_fire,
  output logic done,
  output logic halt
);

  sdma_state_e state_q, state_d;

  always_comb begin
    rd_fire = (state_q == SD_FETCH) && !cyc_odd;
    wr_fire = (state_q == SD_STORE);
    halt    = (state_q != SD_IDLE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SD_IDLE:  if (accept) state_d = SD_LEAD;
      SD_LEAD:  state_d = SD_FETCH;
      SD_FETCH: if (!cyc_odd) state_d = SD_STORE;
      SD_STORE: state_d = last_idx ? SD_IDLE : SD_FETCH;
      default:  state_d = SD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SD_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= wr_fire && last_idx;
    end
  end

endmodule

// File: rtl/sdma_index.sv
module sdma_index #(
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 8,
  parameter int XFER_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              wr_fire,
  output logic [PAGE_W-1:0] page_q,
  output logic [CNT_W-1:0]  idx_q,
  output logic              last_idx
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(XFER_BYTES - 1);

  always_comb last_idx = (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      idx_q  <= '0;
    end else if (accept) begin
      page_q <= page_in;
      idx_q  <= '0;
    end else if (wr_fire) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/sdma_hold.sv
module sdma_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int XFER_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_wr,
  input  logic [DATA_W-1:0] trig_data,
  input  logic              cyc_odd,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              spr_wr,
  output logic [DATA_W-1:0] spr_wdata,
  output logic              halt,
  output logic              done
);

  localparam int CNT_W  = $clog2(XFER_BYTES);
  localparam int PAGE_W = ADDR_W - CNT_W;

  function automatic logic [ADDR_W-1:0] src_addr(input logic [PAGE_W-1:0] pg,
                                                 input logic [CNT_W-1:0]  ix);
    return {pg, ix};
  endfunction

  // Named internal events, observed by the bound checker.
  logic              accept;
  logic              rd_fire;
  logic              wr_fire;
  logic              last_idx;
  logic [PAGE_W-1:0] page_in;
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  idx_q;

  generate
    if (PAGE_W <= DATA_W) begin : g_page_trunc
      assign page_in = trig_data[PAGE_W-1:0];
    end else begin : g_page_ext
      assign page_in = {{(PAGE_W-DATA_W){1'b0}}, trig_data};
    end
  endgenerate

  assign accept = trig_wr && !halt;

  sdma_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .cyc_odd  (cyc_odd),
    .last_idx (last_idx),
    .rd_fire  (rd_fire),
    .wr_fire  (wr_fire),
    .done     (done),
    .halt     (halt)
  );

  sdma_index #(
    .PAGE_W     (PAGE_W),
    .CNT_W      (CNT_W),
    .XFER_BYTES (XFER_BYTES)
  ) u_index (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .page_in  (page_in),
    .wr_fire  (wr_fire),
    .page_q   (page_q),
    .idx_q    (idx_q),
    .last_idx (last_idx)
  );

  sdma_hold #(.DATA_W(DATA_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (rd_fire),
    .d    (bus_rdata),
    .q    (spr_wdata)
  );

  assign bus_rd   = rd_fire;
  assign spr_wr   = wr_fire;
  assign bus_addr = src_addr(page_q, idx_q);

endmodule

// File: rtl/sdma_chk.sv
module sdma_chk
  import sdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int XFER_BYTES = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_odd,
  input logic              accept,
  input logic              rd_fire,
  input logic              wr_fire,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              spr_wr,
  input logic [DATA_W-1:0] spr_wdata,
  input logic              halt,
  input logic              done
);

  localparam int CNT_W = $clog2(XFER_BYTES);

  logic [15:0] halt_len_q;
  logic [15:0] wr_num_q;
  logic        odd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_len_q <= '0;
      wr_num_q   <= '0;
      odd_q      <= 1'b0;
    end else begin
      halt_len_q <= halt ? halt_len_q + 16'd1 : 16'd0;
      wr_num_q   <= !halt ? 16'd0 : (spr_wr ? wr_num_q + 16'd1 : wr_num_q);
      if (accept) odd_q <= cyc_odd;
    end
  end

  assert_rd_even_R4: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> !cyc_odd);
  assert_wr_odd_R4: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> cyc_odd);
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && spr_wr));
  assert_rd_then_wr_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> spr_wr);
  assert_wr_data_R2: assert property (@(posedge clk) disable iff (rst)
    spr_wr |-> spr_wdata == $past(bus_rdata));
  assert_halt_rise_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> halt);
  assert_lead_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> (!bus_rd && !spr_wr));
  assert_done_after_wr_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!halt && $past(spr_wr)));
  assert_done_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(halt) && !$past(rst)) |-> done);
  assert_page_held_R7: assert property (@(posedge clk) disable iff (rst)
    (halt && $past(halt)) |-> $stable(bus_addr[ADDR_W-1:CNT_W]));
  assert_length_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(halt) && !$past(rst)) |->
      (32'(halt_len_q) == sdma_xfer_cycles(XFER_BYTES, odd_q)));
  assert_write_count_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(halt) && !$past(rst)) |-> (32'(wr_num_q) == XFER_BYTES));

endmodule

bind sprite_dma sdma_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .XFER_BYTES (XFER_BYTES)
) u_sdma_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_odd   (cyc_odd),
  .accept    (accept),
  .rd_fire   (rd_fire),
  .wr_fire   (wr_fire),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .spr_wr    (spr_wr),
  .spr_wdata (spr_wdata),
  .halt      (halt),
  .done      (done)
);

// File: tb/test_sprite_dma.sv
module test_sprite_dma;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_wr = 1'b0;
  logic [7:0]  trig_data = 8'h00;
  logic        cyc_odd;
  logic        bus_rd;
  logic [15:0] bus_addr;
  logic [7:0]  bus_rdata;
  logic        spr_wr;
  logic [7:0]  spr_wdata;
  logic        halt;
  logic        done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) cyc_odd <= 1'b0;
    else     cyc_odd <= ~cyc_odd;
  end

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ (a[15:8] * 8'd29) ^ 8'hA5;
  endfunction

  function automatic int exp_halt_cycles(input bit odd);
    return 2 * NBYTES + 1 + (odd ? 1 : 0);
  endfunction

  assign bus_rdata = src_byte(bus_addr);

  sprite_dma i_sprite_dma (
    .clk       (clk),
    .rst       (rst),
    .trig_wr   (trig_wr),
    .trig_data (trig_data),
    .cyc_odd   (cyc_odd),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .spr_wr    (spr_wr),
    .spr_wdata (spr_wdata),
    .halt      (halt),
    .done      (done)
  );

  // Sprite memory model and transfer monitor, sampled mid-cycle.
  logic [7:0]  oam [256];
  logic [7:0]  oam_ptr;
  logic [15:0] exp_base;
  int hl_cnt, rd_cnt, wr_cnt, addr_err, par_err, done_cnt, done_err, first_rd;

  task automatic clear_stats(input logic [7:0] page);
    hl_cnt = 0; rd_cnt = 0; wr_cnt = 0; addr_err = 0; par_err = 0;
    done_cnt = 0; done_err = 0; first_rd = -1;
    exp_base = {page, 8'h00};
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_rd) begin
        if (rd_cnt == 0) first_rd = hl_cnt;
        if (bus_addr != exp_base + 16'(rd_cnt)) addr_err++;
        if (cyc_odd) par_err++;
        rd_cnt++;
      end
      if (spr_wr) begin
        oam[oam_ptr] = spr_wdata;
        oam_ptr = oam_ptr + 8'd1;
        if (!cyc_odd) par_err++;
        wr_cnt++;
      end
      if (done) begin
        done_cnt++;
        if (halt) done_err++;
      end
      if (halt) hl_cnt++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic trigger(input logic [7:0] page, input bit odd);
    @(negedge clk);
    while (cyc_odd != odd) @(negedge clk);
    trig_wr   = 1'b1;
    trig_data = page;
    @(negedge clk);
    trig_wr   = 1'b0;
  endtask

  task automatic run(input logic [7:0] page, input bit odd,
                     input logic [7:0] ptr0, input int spur_at);
    int guard;
    int mism;
    @(negedge clk);
    oam_ptr = ptr0;
    clear_stats(page);
    trigger(page, odd);
    if (spur_at > 0) begin
      repeat (spur_at - 1) @(negedge clk);
      trig_wr   = 1'b1;
      trig_data = ~page;
      @(negedge clk);
      trig_wr   = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk("R3 transfer completes", (done_cnt > 0) ? 1 : 0, 1);
    chk("R3 halt cycles", hl_cnt, exp_halt_cycles(odd));
    chk("R2 read count", rd_cnt, NBYTES);
    chk("R2 write count", wr_cnt, NBYTES);
    chk("R1 source addresses", addr_err, 0);
    chk("R4 cycle parity", par_err, 0);
    chk("R5 first read slot", first_rd, odd ? 2 : 1);
    chk("R6 done pulses", done_cnt, 1);
    chk("R6 done with halt low", done_err, 0);
    mism = 0;
    for (int i = 0; i < NBYTES; i++) begin
      if (oam[8'(int'(ptr0) + i)] != src_byte({page, 8'(i)})) mism++;
    end
    chk("R9 sprite contents", mism, 0);
    if (spur_at > 0) chk("R7 spurious trigger ignored", addr_err + mism, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL R3 watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24601));
    oam_ptr = 8'h00;
    clear_stats(8'h00);
    repeat (4) @(negedge clk);
    chk("R8 halt in reset", int'(halt), 0);
    chk("R8 done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 no bus read after reset", int'(bus_rd), 0);
    chk("R8 no sprite write after reset", int'(spr_wr), 0);

    // Directed corners.
    run(8'h00, 1'b0, 8'h00, 0);
    run(8'hFF, 1'b1, 8'hFD, 0);
    run(8'h3C, 1'b0, 8'h80, 1);
    run(8'hC2, 1'b1, 8'h10, 400);
    run(8'h80, 1'b0, 8'hFF, 513);

    // Random transfers.
    for (int n = 0; n < 8; n++) begin
      logic [7:0] pg;
      logic [7:0] pt;
      bit od;
      int sp;
      pg = 8'($urandom);
      pt = 8'($urandom);
      od = 1'($urandom);
      sp = (($urandom % 3) == 0) ? int'(1 + ($urandom % 500)) : 0;
      run(pg, od, pt, sp);
    end

    // Reset in the middle of a copy.
    trigger(8'h5A, 1'b0);
    repeat (150) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 halt cleared by reset", int'(halt), 0);
    chk("R8 done low in reset", int'(done), 0);
    chk("R8 sprite write low in reset", int'(spr_wr), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 bus idle after reset", int'(bus_rd), 0);
    run(8'h21, 1'b1, 8'h04, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule